// File: doc/BRIEF.md
# System Address Decoder with Video Page Flipping

This block turns a 32-bit processor address into a single chip select for one of four targets: main RAM, boot ROM, one of eight I/O device slots, or video RAM. Alongside the select it produces the offset that the chosen target sees. The address map is sparse and is decoded coarsely. Every address inside an I/O slot reaches the same single device register. Any address that falls outside the populated windows raises a decode-error flag instead of a select.

The block also owns the double-buffering state for video memory. A one-bit register names the page that the display scans. The processor is always steered to the other physical page, so it never writes the picture being shown. Software asks for a swap with a one-cycle request strobe. The swap itself is held back until the next start-of-frame pulse, so the roles change only at a frame boundary.

Address decode is combinational and always accepts. The address strobe has no ready signal and no back-pressure: a valid address is decoded in the same cycle it is presented. The flip request and the start-of-frame pulse are plain control strobes sampled on the rising clock edge.

Top module: `sysmap_decoder`

## Requirements
- R1: With the address valid and bits 31..24 all zero, only sel_ram_o is high and local_off_o equals address bits 23..0.
- R2: With the address valid and bits 31..20 equal to 0xFF0, only sel_rom_o is high and local_off_o equals address bits 19..0, zero-extended.
- R3: With the address valid and bits 31..20 equal to 0xFFE, exactly one bit of sel_io_o is high: bit k for address bits 19..17 equal to k. From 0xFFE0_0000 upward, the slots are: terminal output (0), keyboard input (1), storage interface (2), serial ports 0 to 3 (3 to 6), and video controls (7).
- R4: For any I/O slot access, local_off_o is zero whatever the low 17 address bits are, so the whole slot aliases to one register.
- R5: With the address valid and bits 31..18 all ones (0xFFFC_0000 to 0xFFFF_FFFF, logical page 0 below page 1), only sel_vram_o is high and local_off_o equals address bits 16..0. The physical page for the access is cpu_page_o for both logical pages.
- R6: A valid address outside the windows of R1, R2, R3 and R5 raises decode_err_o, keeps every select low and drives local_off_o to zero.
- R7: While addr_valid_i is low, every select, decode_err_o and local_off_o are zero.
- R8: After reset, disp_page_o is 0, cpu_page_o is 1 and flip_pending_o is 0.
- R9: A flip_req_i pulse sets flip_pending_o in the next cycle. A frame_start_i pulse while the flip is pending inverts disp_page_o in the next cycle and clears the pending flag, unless flip_req_i is high in that same cycle, which re-arms it.
- R10: disp_page_o changes only after a frame_start_i with a flip pending. A frame start with nothing pending, and any number of repeated requests before a frame start, give no extra change.
- R11: cpu_page_o is always the inverse of disp_page_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 32 | Processor address |
| addr_valid_i | input | 1 | Address strobe qualifying addr_i |
| flip_req_i | input | 1 | Request a video page swap at the next frame start |
| frame_start_i | input | 1 | One-cycle pulse just before a new frame |
| sel_ram_o | output | 1 | Main RAM select |
| sel_rom_o | output | 1 | ROM select |
| sel_io_o | output | 8 | One-hot I/O slot selects |
| sel_vram_o | output | 1 | Video RAM select |
| decode_err_o | output | 1 | Valid access to an unmapped address |
| local_off_o | output | 24 | Offset within the selected target |
| disp_page_o | output | 1 | Page scanned by the display |
| cpu_page_o | output | 1 | Physical page used by processor video accesses |
| flip_pending_o | output | 1 | A swap is waiting for the frame boundary |

## Verification
The case that is hardest to reach from the ports is a flip request that lands in the same cycle as a start-of-frame pulse while an earlier request is still pending. The swap must happen and the new request must stay armed for the following frame. The bench arms a request, then raises both strobes together on one negative edge. It checks the page and the pending flag after that edge and again after a lone frame pulse. Both video page windows are probed before and after a swap, to show that the processor always lands on the hidden page.

// File: rtl/sysmap_pkg.sv
`timescale 1ns/1ps
package sysmap_pkg;
  // Coarse region classes produced by the address classifier.
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,
    RG_RAM  = 3'd1,
    RG_ROM  = 3'd2,
    RG_IO   = 3'd3,
    RG_VRAM = 3'd4
  } region_e;
endpackage

// File: rtl/sysmap_region_decode.sv
`timescale 1ns/1ps
module sysmap_region_decode
  import sysmap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int OFF_W       = 24,
  parameter int RAM_OFF_W   = 24,
  parameter int ROM_OFF_W   = 20,
  parameter int SLOT_W      = 17,
  parameter int N_IO        = 8,
  parameter int VPAGE_W     = 17,
  parameter logic [ADDR_W-1:0] ROM_BASE  = 32'hFF00_0000,
  parameter logic [ADDR_W-1:0] IO_BASE   = 32'hFFE0_0000,
  parameter logic [ADDR_W-1:0] VRAM_BASE = 32'hFFFC_0000,
  localparam int IDX_W      = $clog2(N_IO),
  localparam int IO_BLK_W   = SLOT_W + IDX_W,
  localparam int VSPAN_W    = VPAGE_W + 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [IDX_W-1:0]  slot_o
);
  logic hit_ram, hit_rom, hit_io, hit_vram;

  // Each window is identified by the address bits above its span.
  assign hit_ram  = (addr_i[ADDR_W-1:RAM_OFF_W] == '0);
  assign hit_rom  = (addr_i[ADDR_W-1:ROM_OFF_W] == ROM_BASE[ADDR_W-1:ROM_OFF_W]);
  assign hit_io   = (addr_i[ADDR_W-1:IO_BLK_W]  == IO_BASE[ADDR_W-1:IO_BLK_W]);
  assign hit_vram = (addr_i[ADDR_W-1:VSPAN_W]   == VRAM_BASE[ADDR_W-1:VSPAN_W]);

  assign slot_o = addr_i[IO_BLK_W-1:SLOT_W];

  always_comb begin
    region_o = RG_NONE;
    off_o    = '0;
    if (hit_ram) begin
      region_o = RG_RAM;
      off_o    = OFF_W'(addr_i[RAM_OFF_W-1:0]);
    end else if (hit_rom) begin
      region_o = RG_ROM;
      off_o    = OFF_W'(addr_i[ROM_OFF_W-1:0]);
    end else if (hit_io) begin
      // Slot aliasing: the low bits inside a slot are dropped.
      region_o = RG_IO;
      off_o    = '0;
    end else if (hit_vram) begin
      // Logical page bit is dropped; the physical page comes from the flip state.
      region_o = RG_VRAM;
      off_o    = OFF_W'(addr_i[VPAGE_W-1:0]);
    end
  end
endmodule

// File: rtl/sysmap_io_onehot.sv
`timescale 1ns/1ps
module sysmap_io_onehot #(
  parameter int N_IO  = 8,
  localparam int IDX_W = $clog2(N_IO)
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [N_IO-1:0]  sel_o
);
  for (genvar k = 0; k < N_IO; k++) begin : g_slot
    assign sel_o[k] = en_i && (idx_i == IDX_W'(k));
  end
endmodule

// File: rtl/sysmap_page_flip.sv
`timescale 1ns/1ps
module sysmap_page_flip (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_req_i,
  input  logic frame_start_i,
  output logic disp_page_o,
  output logic pending_o
);
  logic disp_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (frame_start_i && pend_q) disp_q <= ~disp_q;
      // A request in the frame-start cycle re-arms for the following frame.
      pend_q <= flip_req_i | (pend_q & ~frame_start_i);
    end
  end

  assign disp_page_o = disp_q;
  assign pending_o   = pend_q;
endmodule

// File: rtl/sysmap_decoder.sv
`timescale 1ns/1ps
module sysmap_decoder
  import sysmap_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 24,
  parameter int N_IO    = 8,
  parameter int SLOT_W  = 17,
  parameter int VPAGE_W = 17,
  localparam int IDX_W  = $clog2(N_IO)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              addr_valid_i,
  input  logic              flip_req_i,
  input  logic              frame_start_i,
  output logic              sel_ram_o,
  output logic              sel_rom_o,
  output logic [N_IO-1:0]   sel_io_o,
  output logic              sel_vram_o,
  output logic              decode_err_o,
  output logic [OFF_W-1:0]  local_off_o,
  output logic              disp_page_o,
  output logic              cpu_page_o,
  output logic              flip_pending_o
);
  region_e            region;
  logic [OFF_W-1:0]   off_raw;
  logic [IDX_W-1:0]   slot;

  sysmap_region_decode #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SLOT_W (SLOT_W),
    .N_IO   (N_IO),
    .VPAGE_W(VPAGE_W)
  ) u_region (
    .addr_i  (addr_i),
    .region_o(region),
    .off_o   (off_raw),
    .slot_o  (slot)
  );

  sysmap_io_onehot #(.N_IO(N_IO)) u_io (
    .en_i (addr_valid_i && (region == RG_IO)),
    .idx_i(slot),
    .sel_o(sel_io_o)
  );

  sysmap_page_flip u_flip (
    .clk          (clk),
    .rst_n        (rst_n),
    .flip_req_i   (flip_req_i),
    .frame_start_i(frame_start_i),
    .disp_page_o  (disp_page_o),
    .pending_o    (flip_pending_o)
  );

  assign sel_ram_o    = addr_valid_i && (region == RG_RAM);
  assign sel_rom_o    = addr_valid_i && (region == RG_ROM);
  assign sel_vram_o   = addr_valid_i && (region == RG_VRAM);
  assign decode_err_o = addr_valid_i && (region == RG_NONE);
  assign local_off_o  = addr_valid_i ? off_raw : '0;
  // The processor is always steered to the page the display is not scanning.
  assign cpu_page_o   = ~disp_page_o;
endmodule

// File: rtl/sysmap_decoder_chk.sv
`timescale 1ns/1ps
module sysmap_decoder_chk #(
  parameter int N_IO = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            addr_valid_i,
  input logic            flip_req_i,
  input logic            frame_start_i,
  input logic            sel_ram_o,
  input logic            sel_rom_o,
  input logic [N_IO-1:0] sel_io_o,
  input logic            sel_vram_o,
  input logic            decode_err_o,
  input logic            disp_page_o,
  input logic            cpu_page_o,
  input logic            flip_pending_o
);
  logic any_sel;
  assign any_sel = sel_ram_o | sel_rom_o | (|sel_io_o) | sel_vram_o;

  p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_ram_o, sel_rom_o, sel_io_o, sel_vram_o, decode_err_o}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid_i |-> (!any_sel && !decode_err_o));

  p_err_alone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    decode_err_o |-> !any_sel);

  p_page_split_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_page_o != disp_page_o);

  p_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flip_req_i |=> flip_pending_o);

  p_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start_i && flip_pending_o) |=> (disp_page_o != $past(disp_page_o)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start_i && flip_pending_o) |=> $stable(disp_page_o));
endmodule

bind sysmap_decoder sysmap_decoder_chk #(.N_IO(N_IO)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_valid_i  (addr_valid_i),
  .flip_req_i    (flip_req_i),
  .frame_start_i (frame_start_i),
  .sel_ram_o     (sel_ram_o),
  .sel_rom_o     (sel_rom_o),
  .sel_io_o      (sel_io_o),
  .sel_vram_o    (sel_vram_o),
  .decode_err_o  (decode_err_o),
  .disp_page_o   (disp_page_o),
  .cpu_page_o    (cpu_page_o),
  .flip_pending_o(flip_pending_o)
);

// File: tb/sysmap_decoder_tb.sv
`timescale 1ns/1ps
module sysmap_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        valid = 1'b0;
  logic        flip_req = 1'b0;
  logic        frame_start = 1'b0;
  logic        sel_ram, sel_rom, sel_vram, derr;
  logic [7:0]  sel_io;
  logic [23:0] off;
  logic        disp_page, cpu_page, pending;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sysmap_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .addr_valid_i(valid),
    .flip_req_i(flip_req), .frame_start_i(frame_start),
    .sel_ram_o(sel_ram), .sel_rom_o(sel_rom), .sel_io_o(sel_io),
    .sel_vram_o(sel_vram), .decode_err_o(derr), .local_off_o(off),
    .disp_page_o(disp_page), .cpu_page_o(cpu_page), .flip_pending_o(pending)
  );

  // Select code: [11] err, [10] vram, [9:2] io slots, [1] rom, [0] ram.
  function automatic logic [11:0] sel_code();
    return {derr, sel_vram, sel_io, sel_rom, sel_ram};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [11:0] code);
    if (code[0])      return "R1 ram window";
    if (code[1])      return "R2 rom window";
    if (|code[9:2])   return "R3 io slot";
    if (code[10])     return "R5 vram window";
    return "R6 unmapped";
  endfunction

  localparam int NV = 23;
  // {address, expected select code, expected offset}
  localparam logic [67:0] VEC [NV] = '{
    {32'h0000_0000, 12'h001, 24'h000000},
    {32'h00FF_FFFF, 12'h001, 24'hFFFFFF},
    {32'h0012_3456, 12'h001, 24'h123456},
    {32'h0100_0000, 12'h800, 24'h000000},
    {32'hFEFF_FFFF, 12'h800, 24'h000000},
    {32'hFF00_0000, 12'h002, 24'h000000},
    {32'hFF0F_ABCD, 12'h002, 24'h0FABCD},
    {32'hFF10_0000, 12'h800, 24'h000000},
    {32'hFFE0_0000, 12'h004, 24'h000000},
    {32'hFFE2_1234, 12'h008, 24'h000000},
    {32'hFFE4_0000, 12'h010, 24'h000000},
    {32'hFFE6_FFFF, 12'h020, 24'h000000},
    {32'hFFE8_0010, 12'h040, 24'h000000},
    {32'hFFEA_0000, 12'h080, 24'h000000},
    {32'hFFEC_0004, 12'h100, 24'h000000},
    {32'hFFEF_FFFF, 12'h200, 24'h000000},
    {32'hFFF0_0000, 12'h800, 24'h000000},
    {32'hFFFB_FFFF, 12'h800, 24'h000000},
    {32'hFFFC_0000, 12'h400, 24'h000000},
    {32'hFFFD_1234, 12'h400, 24'h011234},
    {32'hFFFE_0042, 12'h400, 24'h000042},
    {32'hFFFF_FFFF, 12'h400, 24'h01FFFF},
    {32'hFFDF_FFFF, 12'h800, 24'h000000}
  };

  task automatic pulse(input logic fr, input logic fs);
    @(negedge clk);
    flip_req = fr;
    frame_start = fs;
    @(negedge clk);
    flip_req = 1'b0;
    frame_start = 1'b0;
    #1;
  endtask

  initial begin
    #2;
    check("R8 reset disp_page", {31'b0, disp_page}, 32'd0);
    check("R8 reset cpu_page", {31'b0, cpu_page}, 32'd1);
    check("R8 reset pending", {31'b0, pending}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Table walk over the address map.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      addr  = VEC[i][67:36];
      valid = 1'b1;
      #1;
      check(tag_of(VEC[i][35:24]), {20'b0, sel_code()}, {20'b0, VEC[i][35:24]});
      check(|VEC[i][11:2] ? "R4 io offset alias" : tag_of(VEC[i][35:24]),
            {8'b0, off}, {8'b0, VEC[i][23:0]});
      if (VEC[i][34]) check("R5 cpu page hidden", {31'b0, cpu_page}, 32'd1);
    end

    // Strobe low: nothing selected, no error, zero offset.
    @(negedge clk); valid = 1'b0; addr = 32'h0012_3456; #1;
    check("R7 idle ram addr", {20'b0, sel_code()}, 32'd0);
    check("R7 idle offset", {8'b0, off}, 32'd0);
    @(negedge clk); addr = 32'h8000_0000; #1;
    check("R7 idle unmapped", {20'b0, sel_code()}, 32'd0);

    // Frame start with nothing pending.
    pulse(1'b0, 1'b1);
    check("R10 no pending frame", {31'b0, disp_page}, 32'd0);

    // Arm, then repeated requests, then swap.
    pulse(1'b1, 1'b0);
    check("R9 pending set", {31'b0, pending}, 32'd1);
    check("R9 not yet swapped", {31'b0, disp_page}, 32'd0);
    pulse(1'b1, 1'b0);
    check("R10 repeat request", {31'b0, disp_page}, 32'd0);
    pulse(1'b0, 1'b1);
    check("R9 swapped", {31'b0, disp_page}, 32'd1);
    check("R9 pending cleared", {31'b0, pending}, 32'd0);
    check("R11 cpu page inverse", {31'b0, cpu_page}, 32'd0);

    // Both logical VRAM pages land on the hidden physical page 0.
    @(negedge clk); valid = 1'b1; addr = 32'hFFFE_0010; #1;
    check("R5 page1 addr to hidden", {31'b0, cpu_page}, 32'd0);
    check("R5 page1 select", {31'b0, sel_vram}, 32'd1);
    @(negedge clk); addr = 32'hFFFC_0010; #1;
    check("R5 page0 addr to hidden", {31'b0, cpu_page}, 32'd0);
    valid = 1'b0;

    // Request coinciding with the swapping frame start re-arms.
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b1);
    check("R9 coincident swap", {31'b0, disp_page}, 32'd0);
    check("R9 coincident rearm", {31'b0, pending}, 32'd1);
    pulse(1'b0, 1'b1);
    check("R9 rearmed swap", {31'b0, disp_page}, 32'd1);
    check("R9 rearmed clear", {31'b0, pending}, 32'd0);
    pulse(1'b0, 1'b1);
    check("R10 idle frame after swap", {31'b0, disp_page}, 32'd1);
    check("R11 cpu page final", {31'b0, cpu_page}, 32'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule